// File: doc/BRIEF.md
# Receive Sampling Phase Tuner

This block finds a good receive sampling phase for a serial card interface. On a start request it walks a phase register from zero up to the present clock divider value. At every phase it asks an external tester to run a fixed group of tuning-block trials. Each trial is a one-cycle start pulse out, followed later by a done strobe that carries a pass or fail flag. A phase counts as good only when every trial in its group passes.

Runs of consecutive good phases form windows. The block keeps the longest closed window and the window still open at the end of the sweep. It then writes the centre of the chosen window into the phase register. If no phase is good, the phase register goes back to the value it held before the sweep and an error flag is raised.

Outside a sweep, the phase register can be written directly. The divider value comes from an input. The pattern transfer itself belongs to the tester.

Top module: `rx_phase_tuner`

## Requirements
- R1: After reset, `phase_o` is 0 and `busy_o`, `done_o`, `error_o` and `trial_start_o` are all low.
- R2: When `busy_o` is low, a high `start_i` begins a sweep. `busy_o` rises and `phase_o` becomes 0 on the next cycle. While `busy_o` is high, `start_i` and `load_i` have no effect.
- R3: The sweep visits every phase from 0 to `divider_i` inclusive, in rising order. `phase_o` takes each new value one cycle before the first `trial_start_o` pulse of that phase's group. It holds still while any trial is being started.
- R4: Each phase gets exactly TRIALS trial pulses (default 10). Each pulse lasts one cycle, and the next pulse comes only after a `trial_done_i` strobe. A phase is good only if all of its trials report `trial_pass_i` high.
- R5: A good phase that follows a bad phase, or that is phase 0, opens a new window. Each further good phase adds one to the window length. A bad phase closes the open window, and that window replaces the best one only if it is strictly longer.
- R6: When the sweep ends with a window still open, that window is chosen only if it is strictly longer than the best closed window. On a tie, the earlier window is kept.
- R7: The chosen phase is the window start plus half the window length, rounded down.
- R8: If no phase was good, `phase_o` returns to its value from just before the start, and `error_o` goes high. `error_o` stays high until the next accepted start, which clears it.
- R9: `done_o` is high for exactly one cycle, the first cycle in which the result is on `phase_o`. In that cycle `busy_o` is already low.
- R10: When `busy_o` is low and `start_i` is low, `load_i` writes `load_phase_i` into `phase_o`, and the new value appears on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a sweep |
| divider_i | input | PHASE_W | Current clock divider value, which is the last phase swept |
| load_i | input | 1 | Direct write of the phase register while idle |
| load_phase_i | input | PHASE_W | Value for the direct write |
| trial_start_o | output | 1 | One-cycle request to the tester to run one trial |
| trial_done_i | input | 1 | Tester strobe: the trial has finished |
| trial_pass_i | input | 1 | Trial result, sampled with `trial_done_i` |
| phase_o | output | PHASE_W | Receive sampling phase register |
| busy_o | output | 1 | A sweep is in progress |
| done_o | output | 1 | One-cycle pulse when the result is applied |
| error_o | output | 1 | The last sweep found no good phase |

## Verification
The assertions assume three things about the inputs. First, `divider_i` stays constant while `busy_o` is high. Second, `trial_done_i` is strobed only after the matching `trial_start_o`. Third, the tester answers each trial request once. The phase-bound and phase-step checks rely on these. The bench sets the divider before each start and holds it for the whole sweep. Its tester model answers every request exactly once, one cycle later, and picks its pass or fail result from a per-phase map. An optional flaky phase fails only the last trial of its group.

// File: rtl/rx_tune_pkg.sv
package rx_tune_pkg;

   typedef enum logic [2:0] {
      TS_IDLE   = 3'd0,
      TS_PREP   = 3'd1,
      TS_LAUNCH = 3'd2,
      TS_WAIT   = 3'd3,
      TS_EVAL   = 3'd4,
      TS_FINISH = 3'd5
   } tune_state_e;

endpackage

// File: rtl/rx_tune_trials.sv
// Counts the trials of one phase group and folds their pass flags together.
module rx_tune_trials #(
   parameter int TRIALS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic accept_i,
   input  logic pass_i,
   output logic group_end_o,
   output logic group_ok_o
);

   logic all_ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        all_ok_q <= 1'b1;
      else if (clear_i)  all_ok_q <= 1'b1;
      else if (accept_i) all_ok_q <= all_ok_q & pass_i;
   end

   assign group_ok_o = all_ok_q;

   generate
      if (TRIALS == 1) begin : g_single
         assign group_end_o = accept_i;
      end else begin : g_counted
         localparam int CNT_W = $clog2(TRIALS);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIALS - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (clear_i)  cnt_q <= '0;
            else if (accept_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end

         assign group_end_o = accept_i && (cnt_q == LAST);

         // R4: the trial index never passes the last trial of a group
         a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
      end
   endgenerate

endmodule

// File: rtl/rx_tune_window.sv
// Tracks the open window and the best closed window, and picks the result.
module rx_tune_window #(
   parameter int PHASE_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               step_i,
   input  logic               pass_i,
   input  logic [PHASE_W-1:0] phase_i,
   output logic [PHASE_W-1:0] sel_o,
   output logic               none_o
);

   localparam int LEN_W = PHASE_W + 1;

   logic [PHASE_W-1:0] cur_start_q, best_start_q;
   logic [LEN_W-1:0]   cur_len_q, best_len_q;
   logic [LEN_W-1:0]   half_len;
   logic [PHASE_W-1:0] base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_start_q  <= '0;
         cur_len_q    <= '0;
         best_start_q <= '0;
         best_len_q   <= '0;
      end else if (clear_i) begin
         cur_start_q  <= '0;
         cur_len_q    <= '0;
         best_start_q <= '0;
         best_len_q   <= '0;
      end else if (step_i) begin
         if (pass_i) begin
            if (cur_len_q == '0) cur_start_q <= phase_i;
            cur_len_q <= cur_len_q + 1'b1;
         end else begin
            if (cur_len_q > best_len_q) begin
               best_start_q <= cur_start_q;
               best_len_q   <= cur_len_q;
            end
            cur_len_q <= '0;
         end
      end
   end

   always_comb begin
      if (cur_len_q > best_len_q) begin
         base     = cur_start_q;
         half_len = cur_len_q >> 1;
      end else begin
         base     = best_start_q;
         half_len = best_len_q >> 1;
      end
      sel_o  = base + half_len[PHASE_W-1:0];
      none_o = (cur_len_q == '0) && (best_len_q == '0);
   end

   // R5: the best window length only grows within a sweep
   a_r5_best_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clear_i) |-> best_len_q >= $past(best_len_q));

   // R5: a failing evaluation always leaves the open window empty
   a_r5_fail_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !pass_i && !clear_i) |=> cur_len_q == '0);

endmodule

// File: rtl/rx_phase_tuner.sv
module rx_phase_tuner
   import rx_tune_pkg::*;
#(
   parameter int PHASE_W = 12,
   parameter int TRIALS  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [PHASE_W-1:0] divider_i,
   input  logic               load_i,
   input  logic [PHASE_W-1:0] load_phase_i,
   output logic               trial_start_o,
   input  logic               trial_done_i,
   input  logic               trial_pass_i,
   output logic [PHASE_W-1:0] phase_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               error_o
);

   generate
      if (PHASE_W < 1) begin : g_bad_width
         $error("PHASE_W must be at least 1");
      end
      if (TRIALS < 1) begin : g_bad_trials
         $error("TRIALS must be at least 1");
      end
   endgenerate

   tune_state_e        state_q;
   logic [PHASE_W-1:0] phase_q, saved_q;
   logic               err_q, done_q;

   logic group_end, group_ok;
   logic [PHASE_W-1:0] sel_phase;
   logic none_found;
   logic accept_go;

   assign accept_go = (state_q == TS_IDLE) && start_i;

   rx_tune_trials #(.TRIALS(TRIALS)) u_trials (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (state_q == TS_PREP),
      .accept_i    ((state_q == TS_WAIT) && trial_done_i),
      .pass_i      (trial_pass_i),
      .group_end_o (group_end),
      .group_ok_o  (group_ok)
   );

   rx_tune_window #(.PHASE_W(PHASE_W)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (accept_go),
      .step_i  (state_q == TS_EVAL),
      .pass_i  (group_ok),
      .phase_i (phase_q),
      .sel_o   (sel_phase),
      .none_o  (none_found)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TS_IDLE;
         phase_q <= '0;
         saved_q <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            TS_IDLE: begin
               if (start_i) begin
                  saved_q <= phase_q;
                  phase_q <= '0;
                  err_q   <= 1'b0;
                  state_q <= TS_PREP;
               end else if (load_i) begin
                  phase_q <= load_phase_i;
               end
            end
            TS_PREP:   state_q <= TS_LAUNCH;
            TS_LAUNCH: state_q <= TS_WAIT;
            TS_WAIT: begin
               if (group_end)         state_q <= TS_EVAL;
               else if (trial_done_i) state_q <= TS_LAUNCH;
            end
            TS_EVAL: begin
               if (phase_q == divider_i) begin
                  state_q <= TS_FINISH;
               end else begin
                  phase_q <= phase_q + 1'b1;
                  state_q <= TS_PREP;
               end
            end
            TS_FINISH: begin
               phase_q <= none_found ? saved_q : sel_phase;
               err_q   <= none_found;
               done_q  <= 1'b1;
               state_q <= TS_IDLE;
            end
            default: state_q <= TS_IDLE;
         endcase
      end
   end

   assign trial_start_o = (state_q == TS_LAUNCH);
   assign busy_o        = (state_q != TS_IDLE);
   assign phase_o       = phase_q;
   assign done_o        = done_q;
   assign error_o       = err_q;

   // R4: trial pulses last a single cycle
   a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      trial_start_o |=> !trial_start_o);

   // R3: the phase is settled when a trial is started
   a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      trial_start_o |-> $stable(phase_o));

   // R3: within a sweep the phase only steps upward by one
   a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && !$stable(phase_o)) |-> phase_o == $past(phase_o) + 1'b1);

   // R3: the sweep never passes the divider value
   a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> phase_o <= divider_i);

   // R9: the done pulse comes with busy already low and lasts one cycle
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R8: the error flag is only visible while idle
   a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      error_o |-> !busy_o);

endmodule

// File: tb/rx_phase_tuner_tb.sv
module rx_phase_tuner_tb;

   localparam int PW = 12;
   localparam int NT = 10;
   localparam int NV = 11;

   // fields: div[47:44] map[43:28] flaky[27:23] init[22:15] exp[14:7] err[6]
   localparam logic [47:0] VEC [NV] = '{
      {4'd7,  16'h003C, 5'd31, 8'd3, 8'd4,  1'b0, 6'd0},
      {4'd7,  16'h00FF, 5'd31, 8'd3, 8'd4,  1'b0, 6'd0},
      {4'd7,  16'h0000, 5'd31, 8'd9, 8'd9,  1'b1, 6'd0},
      {4'd8,  16'h01C7, 5'd31, 8'd0, 8'd1,  1'b0, 6'd0},
      {4'd8,  16'h01E3, 5'd31, 8'd0, 8'd7,  1'b0, 6'd0},
      {4'd5,  16'h003E, 5'd3,  8'd0, 8'd2,  1'b0, 6'd0},
      {4'd0,  16'h0001, 5'd31, 8'd5, 8'd0,  1'b0, 6'd0},
      {4'd0,  16'h0000, 5'd31, 8'd5, 8'd5,  1'b1, 6'd0},
      {4'd4,  16'h001C, 5'd31, 8'd0, 8'd3,  1'b0, 6'd0},
      {4'd15, 16'h8000, 5'd31, 8'd0, 8'd15, 1'b0, 6'd0},
      {4'd6,  16'h0049, 5'd31, 8'd2, 8'd0,  1'b0, 6'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [PW-1:0] divider_i = '0;
   logic load_i = 1'b0;
   logic [PW-1:0] load_phase_i = '0;
   logic trial_start_o;
   logic trial_done_i = 1'b0;
   logic trial_pass_i = 1'b0;
   logic [PW-1:0] phase_o;
   logic busy_o, done_o, error_o;

   int checks = 0;
   int fails = 0;

   // tester model state
   logic [15:0] pass_map = '0;
   int flaky = 31;
   int tcount = 0;
   int order_err = 0;
   bit pending = 1'b0;
   bit pend_pass = 1'b0;

   always #4 clk = ~clk;

   rx_phase_tuner #(.PHASE_W(PW), .TRIALS(NT)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .divider_i(divider_i),
      .load_i(load_i), .load_phase_i(load_phase_i), .trial_start_o(trial_start_o),
      .trial_done_i(trial_done_i), .trial_pass_i(trial_pass_i), .phase_o(phase_o),
      .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // tester: answers each trial request one cycle later
   initial begin
      forever begin
         @(negedge clk);
         if (pending) begin
            trial_done_i = 1'b1;
            trial_pass_i = pend_pass;
            pending = 1'b0;
         end else begin
            trial_done_i = 1'b0;
            trial_pass_i = 1'b0;
            if (trial_start_o) begin
               int ph;
               ph = int'(phase_o);
               if (ph != tcount / NT) order_err++;
               pend_pass = (ph < 16) && pass_map[ph[3:0]] &&
                           !((ph == flaky) && ((tcount % NT) == NT - 1));
               tcount++;
               pending = 1'b1;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic load_phase(input int v);
      @(negedge clk);
      load_i = 1'b1;
      load_phase_i = PW'(v);
      @(negedge clk);
      load_i = 1'b0;
   endtask

   // runs one sweep; poke pulses start and load during the sweep
   task automatic run(input int div, input logic [15:0] map, input int fl,
                      input bit poke, output int res_phase, output bit res_err);
      bit seen;
      pass_map = map;
      flaky = fl;
      tcount = 0;
      order_err = 0;
      divider_i = PW'(div);
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1 && error_o == 1'b0, "R2 busy after start", int'(busy_o), 1);
      chk(phase_o == '0, "R2 phase zero at start", int'(phase_o), 0);
      if (poke) begin
         repeat (5) @(negedge clk);
         start_i = 1'b1;
         load_i = 1'b1;
         load_phase_i = PW'(170);
         @(negedge clk);
         start_i = 1'b0;
         load_i = 1'b0;
      end
      seen = 1'b0;
      for (int i = 0; i < 2000 && !seen; i++) begin
         @(negedge clk);
         if (done_o) seen = 1'b1;
      end
      chk(seen, "R9 done seen", int'(seen), 1);
      chk(!busy_o, "R9 busy low with done", int'(busy_o), 0);
      res_phase = int'(phase_o);
      res_err = error_o;
      chk(tcount == (div + 1) * NT, "R4 trial count", tcount, (div + 1) * NT);
      chk(order_err == 0, "R3 phase order at trial start", order_err, 0);
      @(negedge clk);
      chk(!done_o, "R9 done single cycle", int'(done_o), 0);
   endtask

   initial begin
      int rp;
      bit re;
      repeat (3) @(negedge clk);
      chk(phase_o == '0 && !busy_o && !done_o && !error_o && !trial_start_o,
          "R1 reset state", int'(phase_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(phase_o == '0 && !busy_o, "R1 state after reset release", int'(busy_o), 0);

      // R10: direct write while idle
      load_phase(37);
      chk(phase_o == PW'(37), "R10 load while idle", int'(phase_o), 37);

      // table walk: R5 R6 R7 R8 through the expected phases
      for (int v = 0; v < NV; v++) begin
         logic [47:0] e;
         e = VEC[v];
         load_phase(int'(e[22:15]));
         run(int'(e[47:44]), e[43:28], int'(e[27:23]), 1'b0, rp, re);
         chk(rp == int'(e[14:7]), "R5 R6 R7 selected phase", rp, int'(e[14:7]));
         chk(re == e[6], "R8 error flag", int'(re), int'(e[6]));
      end

      // R8: error held while idle, cleared by the next accepted start
      load_phase(12);
      run(3, 16'h0000, 31, 1'b0, rp, re);
      chk(rp == 12 && re, "R8 restore after failing sweep", rp, 12);
      repeat (3) @(negedge clk);
      chk(error_o == 1'b1, "R8 error held while idle", int'(error_o), 1);
      run(3, 16'h000F, 31, 1'b0, rp, re);
      chk(rp == 2 && !re, "R8 error cleared by next sweep", rp, 2);

      // R2: start and load pulsed mid-sweep are ignored
      load_phase(9);
      run(7, 16'h0000, 31, 1'b1, rp, re);
      chk(rp == 9, "R2 load ignored while busy", rp, 9);
      chk(re == 1'b1, "R2 sweep not restarted", int'(re), 1);

      // R10: start has priority over load in the same cycle
      @(negedge clk);
      load_i = 1'b1;
      load_phase_i = PW'(99);
      start_i = 1'b1;
      divider_i = PW'(2);
      pass_map = 16'h0007;
      flaky = 31;
      tcount = 0;
      @(negedge clk);
      load_i = 1'b0;
      start_i = 1'b0;
      chk(phase_o == '0 && busy_o, "R10 start wins over load", int'(phase_o), 0);
      for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
      chk(phase_o == PW'(1), "R7 centre of full sweep", int'(phase_o), 1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule